// File: doc/BRIEF.md
# Peripheral interrupt request aggregator

This block gathers the status flags and enable bits of the on-chip peripherals and turns them into a 32-bit vector of pending interrupt requests. Each bit of the vector stands for one vector number. The peripherals are the serial port, SPI, the free-running timer, the real-time tick, five output compares, three input captures and the pulse accumulator. The vector feeds an interrupt arbiter. The arbiter chooses what to service and can clear bits through an acknowledge mask. The block keeps no copies of peripheral flags and makes no priority decision.

The peripheral bits are rebuilt from their flag and enable inputs on every clock and registered once. The serial port has four flag/enable pairs that all drive one vector. On each update every inactive source first clears its vector, and then every active source sets its vector. Because of this order, one live serial pair keeps the shared request up. The bits that no peripheral drives belong to the processor core (external lines, software trap, illegal opcode). They are set by a raise mask, and they hold until the arbiter acknowledges them.

A free-running cycle counter runs from reset. When any request bit goes from 0 to 1, the counter value at that clock edge is stored as the raise time of that bit, so latency can be measured later. The stored times are read out through a select input.

Top module: `irqagg_top`

## Requirements
- R1: While synchronous reset `rst` is high, the pending vector, the cycle counter and every stored raise time go to zero at the clock edge. On the first edge after reset is released, the counter value taken for a raise time is 0.
- R2: A peripheral source sets its vector bit only when its flag input and its enable input are both 1. Input bit positions: `serFlag/serEn` [0] transmit register empty, [1] transmit complete, [2] receive register full, [3] line idle. `tmrFlag/tmrEn` [0] timer overflow, [1] real-time tick, [2] pulse-accumulator edge, [3] pulse-accumulator overflow. `cmpFlag/cmpEn` [4:0] output compares 1 to 5, [7:5] input captures 1 to 3.
- R3: If the flag or the enable of a source is 0, that source clears its vector bit. When no other source shares that vector, the bit reads 0 after the next edge.
- R4: All four serial pairs drive vector 11. The bit stays 1 while any one of the pairs is active, and it clears only when all four are inactive.
- R5: Vector numbers: serial 11, SPI 12, pulse-accumulator edge 13, pulse-accumulator overflow 14, timer overflow 15, output compare 5 down to 1 on 16 down to 20, input capture 3 down to 1 on 21 down to 23, real-time tick 24.
- R6: On a peripheral vector, a set from an active source wins over every clear in the same cycle, whether the clear comes from an inactive source or from `ackClear`.
- R7: Bits 0 to 10 and 25 to 31 are set by `coreRaise` and hold until `ackClear` clears them. A raise in the same cycle as an acknowledge wins. `coreRaise` and `ackClear` have no effect on bits 11 to 24 beyond what their sources dictate.
- R8: Each bit of `pending` reflects the inputs sampled at the previous clock edge, with exactly one cycle of latency.
- R9: A cycle counter advances by one on every edge out of reset. When a bit goes from 0 to 1, the counter value before that edge is stored as its raise time. `stampOut` shows the time stored for the bit selected by `stampSel`, with no register in between.
- R10: A source whose bit in parameter `GATELESS` is set is treated as always enabled, so its flag alone raises its vector. Source index order: serial pairs 0 to 3, SPI 4, timer overflow 5, real-time tick 6, pulse-accumulator edge 7, pulse-accumulator overflow 8, output compares 1 to 5 on 9 to 13, input captures 1 to 3 on 14 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| serFlag | input | 4 | Serial port status flags |
| serEn | input | 4 | Serial port enables |
| spiFlag | input | 1 | SPI transfer-done flag |
| spiEn | input | 1 | SPI interrupt enable |
| tmrFlag | input | 4 | Timer overflow, tick and pulse-accumulator flags |
| tmrEn | input | 4 | Enables matching `tmrFlag` |
| cmpFlag | input | 8 | Output compare and input capture flags |
| cmpEn | input | 8 | Enables matching `cmpFlag` |
| ackClear | input | 32 | Arbiter clear mask |
| coreRaise | input | 32 | Raise mask for core-owned vectors |
| stampSel | input | 5 | Vector whose raise time is read |
| pending | output | 32 | Registered pending request vector |
| stampOut | output | STAMP_W | Raise time of the selected vector |

## Verification
The assertions assume three things about the inputs. The flag and enable inputs are already synchronous and stable around the clock edge. `ackClear` may name any bit, including peripheral-owned ones. `coreRaise` may also touch peripheral bits, and the design must ignore it there. The stimulus changes inputs only just after the falling edge. It deliberately raises and acknowledges both owned and unowned bits, sometimes in the same cycle. Random phases keep the serial flags dense, so the shared vector often sees both set and clear requests in the same cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int VEC_W   = 32;
  localparam int SEL_W   = $clog2(VEC_W);
  localparam int NUM_SRC = 17;

  // Source indices (order fixed by the top-level flattening)
  localparam int SRC_SER0   = 0;
  localparam int SRC_SPI    = 4;
  localparam int SRC_TOVF   = 5;
  localparam int SRC_TICK   = 6;
  localparam int SRC_PAEDGE = 7;
  localparam int SRC_PAOVF  = 8;
  localparam int SRC_OC1    = 9;
  localparam int SRC_IC1    = 14;

  typedef struct packed {
    logic [VEC_W-1:0] setMask;
    logic [VEC_W-1:0] clrMask;
  } strobe_t;

  // Vector number served by a source index
  function automatic int srcVector(input int s);
    if (s < SRC_SPI)          return 11;
    else if (s == SRC_SPI)    return 12;
    else if (s == SRC_TOVF)   return 15;
    else if (s == SRC_TICK)   return 24;
    else if (s == SRC_PAEDGE) return 13;
    else if (s == SRC_PAOVF)  return 14;
    else if (s < SRC_IC1)     return 20 - (s - SRC_OC1);
    else                      return 23 - (s - SRC_IC1);
  endfunction

  // Vector bits driven by some peripheral source
  function automatic logic [VEC_W-1:0] ownedMask();
    logic [VEC_W-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SRC; s++) m[srcVector(s)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] GATELESS = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcFlag,
  input  logic [NUM_SRC-1:0] srcEn,
  output strobe_t            strb
);

  localparam logic [VEC_W-1:0] OWNED     = ownedMask();
  localparam logic [VEC_W-1:0] SHARE_BIT = VEC_W'(1) << 11;

  logic [NUM_SRC-1:0] live;

  // Per-source gating: an enable-less source follows its flag alone
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (GATELESS[s]) begin : g_open
      assign live[s] = srcFlag[s];
    end else begin : g_gated
      assign live[s] = srcFlag[s] & srcEn[s];
    end
  end

  // Fold sources onto vectors: each source yields a set or a clear
  always_comb begin
    strb.setMask = '0;
    strb.clrMask = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (live[s]) strb.setMask[srcVector(s)] = 1'b1;
      else         strb.clrMask[srcVector(s)] = 1'b1;
    end
  end

  // R5: every owned vector receives a set or a clear, never an unowned one
  a_r5_owned_cover: assert property (@(posedge clk) disable iff (rst)
    (strb.setMask | strb.clrMask) == OWNED);

  // R4: only the shared serial vector may see set and clear together
  a_r4_only_shared_conflict: assert property (@(posedge clk) disable iff (rst)
    ((strb.setMask & strb.clrMask) & ~SHARE_BIT) == '0);

endmodule

// File: rtl/irqagg_dp.sv
module irqagg_dp
  import irqagg_pkg::*;
#(
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strb,
  input  logic [VEC_W-1:0]   ackClear,
  input  logic [VEC_W-1:0]   coreRaise,
  input  logic [SEL_W-1:0]   stampSel,
  output logic [VEC_W-1:0]   pending,
  output logic [STAMP_W-1:0] stampOut
);

  localparam logic [VEC_W-1:0] OWNED = ownedMask();

  logic [VEC_W-1:0]   nextPend;
  logic [VEC_W-1:0]   newBits;
  logic [STAMP_W-1:0] cycleCnt;
  logic [STAMP_W-1:0] stampReg [VEC_W];

  // Clear first, then set; core raise only reaches unowned bits
  always_comb begin
    nextPend = (pending & ~strb.clrMask & ~(ackClear & ~OWNED))
             | strb.setMask
             | (coreRaise & ~OWNED);
    newBits  = nextPend & ~pending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= '0;
      cycleCnt <= '0;
    end else begin
      pending  <= nextPend;
      cycleCnt <= cycleCnt + STAMP_W'(1);
    end
  end

  for (genvar b = 0; b < VEC_W; b++) begin : g_stamp
    always_ff @(posedge clk) begin
      if (rst)             stampReg[b] <= '0;
      else if (newBits[b]) stampReg[b] <= cycleCnt;
    end

    // R9: a freshly raised bit captures the pre-edge count
    a_r9_stamp_capture: assert property (@(posedge clk) disable iff (rst)
      newBits[b] |=> stampReg[b] == $past(cycleCnt));
  end

  assign stampOut = stampReg[stampSel];

  // R6: an active source keeps its vector set after the edge
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pending & $past(strb.setMask)) == $past(strb.setMask));

  // R3: a vector with only clears drops after the edge
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pending & $past(strb.clrMask & ~strb.setMask)) == '0);

  // R7: unowned bits move only under raise or acknowledge
  a_r7_core_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending ^ $past(pending)) & ~OWNED
               & ~$past(coreRaise | ackClear)) == '0);

  // R9: counter advances one per edge out of reset
  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cycleCnt == $past(cycleCnt) + STAMP_W'(1));

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int                 STAMP_W  = 32,
  parameter logic [NUM_SRC-1:0] GATELESS = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         serFlag,
  input  logic [3:0]         serEn,
  input  logic               spiFlag,
  input  logic               spiEn,
  input  logic [3:0]         tmrFlag,
  input  logic [3:0]         tmrEn,
  input  logic [7:0]         cmpFlag,
  input  logic [7:0]         cmpEn,
  input  logic [31:0]        ackClear,
  input  logic [31:0]        coreRaise,
  input  logic [4:0]         stampSel,
  output logic [31:0]        pending,
  output logic [STAMP_W-1:0] stampOut
);

  logic [NUM_SRC-1:0] srcFlag;
  logic [NUM_SRC-1:0] srcEn;
  strobe_t            strb;

  // Flatten into source-index order (see package)
  assign srcFlag = {cmpFlag, tmrFlag, spiFlag, serFlag};
  assign srcEn   = {cmpEn,   tmrEn,   spiEn,   serEn};

  irqagg_ctrl #(.GATELESS(GATELESS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .srcFlag (srcFlag),
    .srcEn   (srcEn),
    .strb    (strb)
  );

  irqagg_dp #(.STAMP_W(STAMP_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .ackClear  (ackClear),
    .coreRaise (coreRaise),
    .stampSel  (stampSel),
    .pending   (pending),
    .stampOut  (stampOut)
  );

endmodule

// File: tb/irqagg_top_test.sv
module irqagg_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  serFlag = '0, serEn = '0;
  logic        spiFlag = 1'b0, spiEn = 1'b0;
  logic [3:0]  tmrFlag = '0, tmrEn = '0;
  logic [7:0]  cmpFlag = '0, cmpEn = '0;
  logic [31:0] ackClear = '0, coreRaise = '0;
  logic [4:0]  stampSel = '0;
  logic [31:0] pending, pendOpen;
  logic [31:0] stampOut, stampOpen;

  int    checks = 0;
  int    fails  = 0;
  string curReq = "R1";
  bit    seenEdge = 0;
  bit    done = 0;

  logic [31:0] mPend;
  int          mCnt;
  int          mStamp [32];

  always #10 clk = ~clk;  // 50 MHz

  irqagg_top uut (
    .clk(clk), .rst(rst), .serFlag(serFlag), .serEn(serEn),
    .spiFlag(spiFlag), .spiEn(spiEn), .tmrFlag(tmrFlag), .tmrEn(tmrEn),
    .cmpFlag(cmpFlag), .cmpEn(cmpEn), .ackClear(ackClear),
    .coreRaise(coreRaise), .stampSel(stampSel),
    .pending(pending), .stampOut(stampOut));

  // SPI source (index 4) built without an enable
  irqagg_top #(.GATELESS(17'h00010)) uutOpen (
    .clk(clk), .rst(rst), .serFlag(serFlag), .serEn(serEn),
    .spiFlag(spiFlag), .spiEn(spiEn), .tmrFlag(tmrFlag), .tmrEn(tmrEn),
    .cmpFlag(cmpFlag), .cmpEn(cmpEn), .ackClear(ackClear),
    .coreRaise(coreRaise), .stampSel(stampSel),
    .pending(pendOpen), .stampOut(stampOpen));

  // Behavioural reference model
  always @(posedge clk) begin
    logic [31:0] act;
    logic        nb;
    seenEdge = 1;
    if (rst) begin
      mPend = '0;
      mCnt  = 0;
      for (int i = 0; i < 32; i++) mStamp[i] = 0;
    end else begin
      act = '0;
      act[11] = |(serFlag & serEn);
      act[12] = spiFlag & spiEn;
      act[13] = tmrFlag[2] & tmrEn[2];
      act[14] = tmrFlag[3] & tmrEn[3];
      act[15] = tmrFlag[0] & tmrEn[0];
      act[24] = tmrFlag[1] & tmrEn[1];
      for (int k = 1; k <= 5; k++) act[21-k] = cmpFlag[k-1] & cmpEn[k-1];
      for (int k = 1; k <= 3; k++) act[24-k] = cmpFlag[4+k] & cmpEn[4+k];
      for (int v = 0; v < 32; v++) begin
        if (v >= 11 && v <= 24) nb = act[v];
        else nb = coreRaise[v] | (mPend[v] & ~ackClear[v]);
        if (nb && !mPend[v]) mStamp[v] = mCnt;
        mPend[v] = nb;
      end
      mCnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (seenEdge && !done) begin
      chk({curReq, " pending"}, pending, mPend);
      chk({curReq, " stamp"}, stampOut, 32'(mStamp[stampSel]));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic quiet();
    serFlag = '0; serEn = '0; spiFlag = 0; spiEn = 0;
    tmrFlag = '0; tmrEn = '0; cmpFlag = '0; cmpEn = '0;
    ackClear = '0; coreRaise = '0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    step(3);
    rst = 0;
    curReq = "R1";
    chk("R1 reset pending", pending, 32'h0);
    chk("R1 reset stamp", stampOut, 32'h0);

    // R1: first edge after reset records count 0
    coreRaise = 32'h0000_0001; stampSel = 5'd0;
    step(1); coreRaise = '0;
    chk("R1 first stamp", stampOut, 32'h0);
    ackClear = 32'h1; step(1); ackClear = '0;

    // R2/R5: single source walk, each gated by flag and enable
    curReq = "R5";
    serFlag = 4'b0100; serEn = 4'b0100; step(1);
    chk("R5 serial vec11", pending, 32'h0000_0800); quiet();
    spiFlag = 1; spiEn = 1; step(1);
    chk("R5 spi vec12", pending, 32'h0000_1000); quiet();
    tmrFlag = 4'b0100; tmrEn = 4'b0100; step(1);
    chk("R5 paedge vec13", pending, 32'h0000_2000); quiet();
    tmrFlag = 4'b1000; tmrEn = 4'b1000; step(1);
    chk("R5 paovf vec14", pending, 32'h0000_4000); quiet();
    tmrFlag = 4'b0001; tmrEn = 4'b0001; step(1);
    chk("R5 tovf vec15", pending, 32'h0000_8000); quiet();
    tmrFlag = 4'b0010; tmrEn = 4'b0010; step(1);
    chk("R5 tick vec24", pending, 32'h0100_0000); quiet();
    cmpFlag = 8'h10; cmpEn = 8'h10; step(1);
    chk("R5 oc5 vec16", pending, 32'h0001_0000); quiet();
    cmpFlag = 8'h01; cmpEn = 8'h01; step(1);
    chk("R5 oc1 vec20", pending, 32'h0010_0000); quiet();
    cmpFlag = 8'h80; cmpEn = 8'h80; step(1);
    chk("R5 ic3 vec21", pending, 32'h0020_0000); quiet();
    cmpFlag = 8'h20; cmpEn = 8'h20; step(1);
    chk("R5 ic1 vec23", pending, 32'h0080_0000); quiet();
    curReq = "R2";
    cmpFlag = 8'hFF; cmpEn = 8'hFF; tmrFlag = 4'hF; tmrEn = 4'hF; step(1);
    chk("R2 all timer", pending, 32'h01FF_E000);

    // R3: drop flag or enable
    curReq = "R3";
    cmpEn = 8'h00; tmrFlag = 4'h0; step(1);
    chk("R3 dropped", pending, 32'h0);
    spiFlag = 1; spiEn = 0; step(1);
    chk("R3 enable off", pending, 32'h0);

    // R10: gateless SPI on second instance
    curReq = "R10";
    chk("R10 open spi", pendOpen & 32'h0000_1000, 32'h0000_1000);
    quiet(); step(1);
    chk("R10 open spi clear", pendOpen & 32'h0000_1000, 32'h0);

    // R4: shared serial vector
    curReq = "R4";
    serFlag = 4'b1001; serEn = 4'b1111; step(1);
    chk("R4 two pairs", pending, 32'h0000_0800);
    serFlag = 4'b1000; step(1);
    chk("R4 one pair left", pending, 32'h0000_0800);
    serEn = 4'b0111; step(1);
    chk("R4 all inactive", pending, 32'h0);

    // R6: acknowledge cannot beat an active source
    curReq = "R6";
    serFlag = 4'b0010; serEn = 4'b0010; ackClear = 32'h0000_0800; step(1);
    chk("R6 ack vs set", pending, 32'h0000_0800);
    step(1);
    chk("R6 ack vs set held", pending, 32'h0000_0800);
    quiet(); step(1);

    // R7: core bits
    curReq = "R7";
    coreRaise = 32'h0800_8000; step(1); coreRaise = '0;
    chk("R7 raise core only", pending, 32'h0800_0000);
    step(3);
    chk("R7 held", pending, 32'h0800_0000);
    ackClear = 32'h0800_0000; coreRaise = 32'h0800_0000; step(1);
    chk("R7 raise beats ack", pending, 32'h0800_0000);
    coreRaise = '0; step(1); ackClear = '0;
    chk("R7 acked", pending, 32'h0);

    // R9: raise time of bit 30
    curReq = "R9";
    stampSel = 5'd30; step(2);
    coreRaise = 32'h4000_0000; step(1); coreRaise = '0;
    chk("R9 stamp bit30", stampOut, 32'(mCnt - 1));
    step(4);
    chk("R9 stamp stable", stampOut, 32'(mCnt - 5));
    ackClear = 32'h4000_0000; step(1); quiet();

    // R8: random traffic compared every cycle
    curReq = "R8";
    for (int i = 0; i < 400; i++) begin
      serFlag = 4'($urandom); serEn = 4'($urandom);
      spiFlag = 1'($urandom); spiEn = 1'($urandom);
      tmrFlag = 4'($urandom); tmrEn = 4'($urandom);
      cmpFlag = 8'($urandom); cmpEn = 8'($urandom);
      coreRaise = $urandom & $urandom & $urandom;
      ackClear = $urandom & $urandom;
      stampSel = 5'($urandom);
      step(1);
    end
    quiet(); step(2);
    finishRun();
  end

endmodule